// File: doc/BRIEF.md
# Partial-Refresh Boundary Selector

This block decides how much of a low-power DRAM must stay in self-refresh before the system sleeps. Software (or a sequencer) presents the number of pages in use and the total page count, which must be a power of two, and pulses `start`. The block rounds the used share of memory up to the nearest supported retention fraction: one sixteenth, one eighth, one quarter, one half or the whole array. It reports the first page index that will lose its contents, whether partial refresh is worth doing at all, and the 3-bit extended-mode code for the chosen fraction.

The code is also returned as a ready-to-write 32-bit command image. That image holds the same 16-bit command twice, once per chip-select pair. Each fit test is a compare of the used count against a right-shifted total, so no divider is needed. Some devices lack the two smallest fractions. For those, a strap input limits the choice to a quarter or larger.

Top module: `pr_boundary_sel`

## Requirements
- R1: While reset is asserted, `done` and `skip_partial` are 0, `refresh_code` is 0, `boundary_page` is 0 and `mode_image` is 0xC000C000.
- R2: `done` is 1 in exactly the cycle after a cycle in which `start` was sampled high, and 0 in every other cycle.
- R3: The chosen fraction is the smallest of 1/16, 1/8, 1/4, 1/2 and 1 whose share of `total_pages` is at least `used_pages`. A used count exactly equal to a fraction's share selects that fraction, so 0 used pages selects 1/16.
- R4: `refresh_code` encodes the chosen fraction as whole array = 0, 1/2 = 1, 1/4 = 2, 1/8 = 5 and 1/16 = 6.
- R5: `boundary_page` equals `total_pages` multiplied by the chosen fraction. Pages below it are retained and pages at or above it are lost.
- R6: When `used_pages` exceeds half of `total_pages`, `skip_partial` is 1, the whole array is chosen (code 0) and `boundary_page` equals `total_pages`. Otherwise `skip_partial` is 0.
- R7: With `small_frac_en` low at start, 1/8 and 1/16 are never chosen, and a small used count yields 1/4 (code 2).
- R8: `mode_image` is 0xC000C000 with `refresh_code` placed in bits [2:0] and again in bits [18:16].
- R9: All result outputs hold their values while `start` is low, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Evaluate the presented counts this cycle |
| used_pages | input | CNT_W | Number of pages in use |
| total_pages | input | CNT_W | Total page count, a power of two |
| small_frac_en | input | 1 | 1 allows the 1/8 and 1/16 fractions |
| done | output | 1 | One-cycle pulse when results are valid |
| boundary_page | output | CNT_W | First page index lost in partial refresh |
| skip_partial | output | 1 | Used share above one half; keep full array |
| refresh_code | output | 3 | Extended-mode partial-refresh code |
| mode_image | output | 32 | Command image with the code for both chip-select pairs |

## Verification
A bad fit compare or a bad priority pick shows up on the `done` pulse of the same request. It appears as a boundary off by a power of two, paired with a code from the neighbouring fraction. The bench stresses this at the exact fit thresholds and one page past them. A corrupted code table shows at once in `refresh_code` and in both fields of `mode_image`. A broken hold or capture enable shows one cycle later, as results that move while `start` is low or a `done` that lingers. The bench watches for these while it toggles the other inputs between requests.

// File: rtl/pr_boundary_pkg.sv
package pr_boundary_pkg;

  // Number of candidate fractions: 1, 1/2, 1/4, 1/8, 1/16
  localparam int unsigned FRAC_STEPS = 5;
  localparam int unsigned SHIFT_W    = $clog2(FRAC_STEPS);
  // Largest shift allowed when the optional fractions are absent
  localparam int unsigned MAND_MAX_SHIFT = 2;

  localparam int unsigned CODE_W   = 3;
  localparam int unsigned IMG_W    = 32;
  localparam logic [IMG_W-1:0] IMG_BASE = 32'hC000_C000;
  localparam int unsigned CODE_LO_POS = 0;
  localparam int unsigned CODE_HI_POS = 16;

  // Non-sequential code per right-shift amount
  function automatic logic [CODE_W-1:0] code_for_shift(input logic [SHIFT_W-1:0] sh);
    logic [CODE_W-1:0] c;
    case (sh)
      3'd0:    c = 3'd0;
      3'd1:    c = 3'd1;
      3'd2:    c = 3'd2;
      3'd3:    c = 3'd5;
      3'd4:    c = 3'd6;
      default: c = 3'd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pr_fit_compare.sv
module pr_fit_compare
  import pr_boundary_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic [CNT_W-1:0]      used,
  input  logic [CNT_W-1:0]      total,
  output logic [FRAC_STEPS-1:0] fits
);

  // fits[k]: the used pages fit in the leading total/2^k pages
  for (genvar k = 0; k < FRAC_STEPS; k++) begin : g_cmp
    logic [CNT_W-1:0] share;
    assign share   = total >> k;
    assign fits[k] = (used <= share);
  end

endmodule

// File: rtl/pr_fraction_pick.sv
module pr_fraction_pick
  import pr_boundary_pkg::*;
(
  input  logic [FRAC_STEPS-1:0] fits,
  input  logic                  small_en,
  output logic [SHIFT_W-1:0]    sel_shift,
  output logic                  skip
);

  // Highest allowed shift that still fits wins (smallest fraction)
  always_comb begin
    sel_shift = '0;
    for (int k = 1; k < FRAC_STEPS; k++) begin
      if (fits[k] && (small_en || (k <= int'(MAND_MAX_SHIFT)))) begin
        sel_shift = SHIFT_W'(k);
      end
    end
  end

  // More than half in use: partial refresh not worthwhile
  assign skip = ~fits[1];

endmodule

// File: rtl/pr_code_pack.sv
module pr_code_pack
  import pr_boundary_pkg::*;
(
  input  logic [SHIFT_W-1:0] sel_shift,
  output logic [CODE_W-1:0]  code,
  output logic [IMG_W-1:0]   image
);

  always_comb begin
    code  = code_for_shift(sel_shift);
    image = IMG_BASE;
    image[CODE_LO_POS +: CODE_W] = code;
    image[CODE_HI_POS +: CODE_W] = code;
  end

endmodule

// File: rtl/pr_boundary_sel.sv
module pr_boundary_sel
  import pr_boundary_pkg::*;
#(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] used_pages,
  input  logic [CNT_W-1:0] total_pages,
  input  logic             small_frac_en,
  output logic             done,
  output logic [CNT_W-1:0] boundary_page,
  output logic             skip_partial,
  output logic [2:0]       refresh_code,
  output logic [31:0]      mode_image
);

  logic [FRAC_STEPS-1:0] fits;
  logic [SHIFT_W-1:0]    sel_shift;
  logic                  skip_c;
  logic [CODE_W-1:0]     code_c;
  logic [IMG_W-1:0]      image_c;

  pr_fit_compare #(.CNT_W(CNT_W)) u_cmp (
    .used  (used_pages),
    .total (total_pages),
    .fits  (fits)
  );

  pr_fraction_pick u_pick (
    .fits      (fits),
    .small_en  (small_frac_en),
    .sel_shift (sel_shift),
    .skip      (skip_c)
  );

  pr_code_pack u_pack (
    .sel_shift (sel_shift),
    .code      (code_c),
    .image     (image_c)
  );

  // Next-state values
  logic             done_d;
  logic [CNT_W-1:0] bound_d;
  logic             skip_d;
  logic [2:0]       code_d;
  logic [31:0]      image_d;
  logic             res_en;

  assign res_en = start;

  always_comb begin
    done_d  = start;
    bound_d = total_pages >> sel_shift;
    skip_d  = skip_c;
    code_d  = code_c;
    image_d = image_c;
  end

  // Handshake register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
    end else begin
      done <= done_d;
    end
  end

  // Result registers, loaded only on start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boundary_page <= '0;
      skip_partial  <= 1'b0;
      refresh_code  <= '0;
      mode_image    <= IMG_BASE;
    end else if (res_en) begin
      boundary_page <= bound_d;
      skip_partial  <= skip_d;
      refresh_code  <= code_d;
      mode_image    <= image_d;
    end
  end

endmodule

// File: rtl/pr_boundary_sel_chk.sv
module pr_boundary_sel_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] total_pages,
  input logic             small_frac_en,
  input logic             done,
  input logic [CNT_W-1:0] boundary_page,
  input logic             skip_partial,
  input logic [2:0]       refresh_code,
  input logic [31:0]      mode_image
);

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(boundary_page) && $stable(skip_partial) && $stable(refresh_code) && $stable(mode_image))); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (refresh_code inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd6})); // R4
  AST_IMAGE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_image[31:16] == mode_image[15:0]) && (mode_image[15:3] == 13'h1800) && (mode_image[2:0] == refresh_code)); // R8
  AST_SKIP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && skip_partial) |-> (refresh_code == 3'd0 && boundary_page == $past(total_pages))); // R6
  AST_NO_SMALL_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(small_frac_en)) |-> (refresh_code != 3'd5 && refresh_code != 3'd6)); // R7
  AST_BOUND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (boundary_page <= $past(total_pages))); // R5

endmodule

bind pr_boundary_sel pr_boundary_sel_chk #(.CNT_W(CNT_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .total_pages   (total_pages),
  .small_frac_en (small_frac_en),
  .done          (done),
  .boundary_page (boundary_page),
  .skip_partial  (skip_partial),
  .refresh_code  (refresh_code),
  .mode_image    (mode_image)
);

// File: tb/pr_boundary_sel_tb_top.sv
module pr_boundary_sel_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 20;
  localparam int WD_CYCLES  = 5000;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [CNT_W-1:0] used_pages;
  logic [CNT_W-1:0] total_pages;
  logic             small_frac_en;
  logic             done;
  logic [CNT_W-1:0] boundary_page;
  logic             skip_partial;
  logic [2:0]       refresh_code;
  logic [31:0]      mode_image;

  pr_boundary_sel #(.CNT_W(CNT_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .used_pages    (used_pages),
    .total_pages   (total_pages),
    .small_frac_en (small_frac_en),
    .done          (done),
    .boundary_page (boundary_page),
    .skip_partial  (skip_partial),
    .refresh_code  (refresh_code),
    .mode_image    (mode_image)
  );

  typedef struct {
    logic [CNT_W-1:0] bound;
    logic             skip;
    logic [2:0]       code;
    logic [31:0]      img;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t last_exp;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   finished = 0;
  logic prev_start = 1'b0;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // Reference from the requirements: real-valued ratio against fractions
  function automatic exp_t model(input int u, input int t, input bit sm, input string tag);
    exp_t e;
    real  r;
    int   k;
    r = real'(u) / real'(t);
    k = 0;
    for (int kk = 4; kk >= 0; kk--) begin
      if ((sm || kk <= 2) && r <= 1.0 / real'(1 << kk)) begin
        k = kk;
        break;
      end
    end
    e.skip  = (r > 0.5);
    case (k)
      0: e.code = 3'd0;
      1: e.code = 3'd1;
      2: e.code = 3'd2;
      3: e.code = 3'd5;
      default: e.code = 3'd6;
    endcase
    e.bound = CNT_W'(t / (1 << k));
    e.img   = 32'hC000_C000 | {13'd0, e.code, 13'd0, e.code};
    e.tag   = tag;
    return e;
  endfunction

  // Driver: called just after a rising edge
  task automatic issue(input int u, input int t, input bit sm, input string tag);
    used_pages    = CNT_W'(u);
    total_pages   = CNT_W'(t);
    small_frac_en = sm;
    start         = 1'b1;
    exp_q.push_back(model(u, t, sm, tag));
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    start = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(done === prev_start, "R2 done pulse", {31'd0, done}, {31'd0, prev_start});
      if (done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(refresh_code === e.code, {"R3 R4 code ", e.tag}, {29'd0, refresh_code}, {29'd0, e.code});
          chk(boundary_page === e.bound, {"R5 boundary ", e.tag}, {12'd0, boundary_page}, {12'd0, e.bound});
          chk(skip_partial === e.skip, {"R6 skip ", e.tag}, {31'd0, skip_partial}, {31'd0, e.skip});
          chk(mode_image === e.img, {"R8 image ", e.tag}, mode_image, e.img);
          last_exp = e;
        end
      end
      prev_start = start;
    end
  end

  // R9: outputs unchanged with start low while other inputs move
  task automatic hold_check();
    used_pages    = CNT_W'(3);
    total_pages   = CNT_W'(64);
    small_frac_en = ~small_frac_en;
    repeat (3) begin @(posedge clk); #1; end
    @(negedge clk);
    chk(refresh_code === last_exp.code, "R9 hold code", {29'd0, refresh_code}, {29'd0, last_exp.code});
    chk(boundary_page === last_exp.bound, "R9 hold boundary", {12'd0, boundary_page}, {12'd0, last_exp.bound});
    chk(mode_image === last_exp.img, "R9 hold image", mode_image, last_exp.img);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n         = 1'b0;
    start         = 1'b0;
    used_pages    = '0;
    total_pages   = CNT_W'(16384);
    small_frac_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(done === 1'b0, "R1 done", {31'd0, done}, 32'd0);
    chk(skip_partial === 1'b0, "R1 skip", {31'd0, skip_partial}, 32'd0);
    chk(refresh_code === 3'd0, "R1 code", {29'd0, refresh_code}, 32'd0);
    chk(boundary_page === '0, "R1 boundary", {12'd0, boundary_page}, 32'd0);
    chk(mode_image === 32'hC000_C000, "R1 image", mode_image, 32'hC000_C000);
    @(posedge clk); #1;
    rst_n = 1'b1;
    idle(2);

    issue(2233, 16384, 1'b1, "R3 2233 of 16384 -> quarter"); idle(2);
    issue(0, 16384, 1'b1, "R3 empty -> sixteenth");         idle(2);
    issue(1024, 16384, 1'b1, "R3 exact sixteenth");         idle(2);
    issue(1025, 16384, 1'b1, "R3 one over sixteenth");      idle(2);
    issue(8192, 16384, 1'b1, "R6 exactly half no skip");    idle(2);
    issue(8193, 16384, 1'b1, "R6 over half skip");          idle(2);
    issue(16384, 16384, 1'b1, "R6 all used");               idle(2);
    issue(10, 16384, 1'b0, "R7 small fractions off");       idle(2);
    issue(2048, 16384, 1'b0, "R7 eighth blocked");          idle(2);
    issue(8, 32, 1'b1, "R5 small array quarter");           idle(2);
    hold_check();
    // R2 back-to-back requests
    issue(3, 32, 1'b1, "R2 back-to-back first");
    issue(16, 32, 1'b1, "R2 back-to-back second");
    issue(40, 32, 1'b1, "R6 over total");
    idle(3);
    hold_check();
    chk(exp_q.size() == 0, "R2 all results seen", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule